// File: doc/BRIEF.md
# Externally Synchronised Channel Start Controller

This block decides when the channels of a multi-channel DAC data path begin running, so that every channel in one core, and every core that shares the same sync wire, starts on the same clock. Software drives it through a small register port. A write to the control register can arm the block, disarm it, request a sync from inside the fabric, or force an immediate start that bypasses the arm logic. While armed, the block watches a synchronised copy of an external sync wire. On that wire's rising edge, or on a manual request, it fires a one-cycle start pulse to every channel and drops back to disarmed.

A status register shows whether the block is armed and waiting. A capability register shows whether the external-sync feature was built in. When the build parameter turns the feature off, only the immediate-start path is left. All command bits are self-clearing: a written 1 acts for one cycle and is never stored.

Top module: `ext_sync_start_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `sync_armed` is 0, `ch_start` is all zeros and the status register (offset 0x68) reads 0.
- R2: A write to the control register (offset 0x44) with bit 1 set and bit 2 clear arms the block. `sync_armed` and status bit 0 read 1 from the cycle after the write edge.
- R3: A control write with bit 2 set disarms the block at the next edge. If bits 1 and 2 are set in the same write, the block ends disarmed.
- R4: While armed, a rising edge on `ext_sync_in` drives every bit of `ch_start` high for exactly one cycle, on the third clock edge after the input rises. At that same edge `sync_armed` returns to 0.
- R5: If `ext_sync_in` is already high when the block is armed, no start occurs. The block stays armed until a new rising edge arrives.
- R6: While armed, a control write with bit 8 set (manual request) and bit 2 clear drives `ch_start` high for one cycle from the write edge, and disarms the block.
- R7: While disarmed, an external rising edge or a manual request produces no start pulse, and the block stays disarmed.
- R8: The control register always reads back 0.
- R9: Bit 12 of the capability register (offset 0x0C) reads 1 when `EXT_SYNC_EN` is 1 and 0 when it is 0. All its other bits read 0.
- R10: With `EXT_SYNC_EN` = 0, control bits 1, 2 and 8 and the external input have no effect. `sync_armed` stays 0 and no start pulse follows them.
- R11: A control write with bit 0 set produces a one-cycle start on all channels from the write edge. This holds for either value of `EXT_SYNC_EN` and does not change the armed state.
- R12: All bits of `ch_start` are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_sync_in | input | 1 | Asynchronous external sync wire, shared between cores |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address for both write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| sync_armed | output | 1 | High while armed and waiting for a sync event |
| ch_start | output | NUM_CH | One-cycle start pulse, one bit per channel |

## Verification
Arm and disarm writes take effect at the write edge, so the bench checks `sync_armed` on the falling edge that follows the write. Manual and immediate starts come from a register loaded at the write edge and are checked on that same falling edge, and again one cycle later to prove the pulse lasts one cycle. An external edge passes through two synchroniser flops and an edge register, so the bench drives the input on a falling edge and expects the start pulse at the third falling edge after that, with no pulse at the second. For the negative cases the bench counts pulses on every falling edge across a window several cycles longer than the sync path, so a late or stray start is also caught.

// File: rtl/ext_sync_pkg.sv
package ext_sync_pkg;

  // Control-register bit positions (decoded by software, so fixed)
  localparam int CTRL_IMMEDIATE_BIT = 0;
  localparam int CTRL_ARM_BIT       = 1;
  localparam int CTRL_DISARM_BIT    = 2;
  localparam int CTRL_MANUAL_BIT    = 8;
  localparam int STAT_ARMED_BIT     = 0;
  localparam int CAP_EXTSYNC_BIT    = 12;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } arm_state_e;

  typedef struct packed {
    logic immediate;
    logic arm;
    logic disarm;
    logic manual;
  } sync_cmd_t;

endpackage

// File: rtl/ext_sync_reg_if.sv
module ext_sync_reg_if
  import ext_sync_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter bit          EXT_SYNC_EN = 1'b1,
  parameter logic [15:0] CTRL_ADDR   = 16'h0044,
  parameter logic [15:0] STAT_ADDR   = 16'h0068,
  parameter logic [15:0] CAP_ADDR    = 16'h000C
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              armed,
  output sync_cmd_t         cmd,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(CAP_ADDR);

  logic ctrl_wr;
  logic unused_wdata;

  assign ctrl_wr      = wr_en && (addr == A_CTRL);
  assign unused_wdata = ^wdata;

  // The immediate start exists in every build
  assign cmd.immediate = ctrl_wr && wdata[CTRL_IMMEDIATE_BIT];

  generate
    if (EXT_SYNC_EN) begin : g_cmd_on
      assign cmd.arm    = ctrl_wr && wdata[CTRL_ARM_BIT];
      assign cmd.disarm = ctrl_wr && wdata[CTRL_DISARM_BIT];
      assign cmd.manual = ctrl_wr && wdata[CTRL_MANUAL_BIT];
    end else begin : g_cmd_off
      assign cmd.arm    = 1'b0;
      assign cmd.disarm = 1'b0;
      assign cmd.manual = 1'b0;
    end
  endgenerate

  // Command bits are never stored, so the control register reads 0
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_STAT:  rdata[STAT_ARMED_BIT]  = armed;
      A_CAP:   rdata[CAP_EXTSYNC_BIT] = EXT_SYNC_EN;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/ext_sync_edge.sv
module ext_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];
  end

  assign rise = chain[LAST] && !prev;

endmodule

// File: rtl/ext_sync_arm_fsm.sv
module ext_sync_arm_fsm
  import ext_sync_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter bit EXT_SYNC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sync_cmd_t         cmd,
  input  logic              ext_rise,
  output logic              armed,
  output logic [NUM_CH-1:0] start
);

  arm_state_e state_q, state_d;
  logic       fire;
  logic       start_d;

  generate
    if (EXT_SYNC_EN) begin : g_fsm
      logic sync_event;
      assign sync_event = cmd.manual || ext_rise;

      always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
          ST_IDLE: begin
            if (cmd.arm && !cmd.disarm) state_d = ST_ARMED;
          end
          ST_ARMED: begin
            if (cmd.disarm) begin
              state_d = ST_IDLE;
            end else if (sync_event) begin
              state_d = ST_IDLE;
              fire    = 1'b1;
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end else begin : g_nofsm
      logic unused_fsm_in;
      assign unused_fsm_in = ext_rise ^ cmd.arm ^ cmd.disarm ^ cmd.manual;
      assign state_d = ST_IDLE;
      assign fire    = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign start_d = fire || cmd.immediate;
  assign armed   = (state_q == ST_ARMED);

  // One flop per channel keeps fan-out local to each lane
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n) start[c] <= 1'b0;
        else        start[c] <= start_d;
      end
    end
  endgenerate

endmodule

// File: rtl/ext_sync_start_ctrl.sv
module ext_sync_start_ctrl
  import ext_sync_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          NUM_CH      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter bit          EXT_SYNC_EN = 1'b1,
  parameter logic [15:0] CTRL_ADDR   = 16'h0044,
  parameter logic [15:0] STAT_ADDR   = 16'h0068,
  parameter logic [15:0] CAP_ADDR    = 16'h000C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sync_in,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sync_armed,
  output logic [NUM_CH-1:0] ch_start
);

  sync_cmd_t cmd;
  logic      ext_rise;

  ext_sync_reg_if #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_SYNC_EN(EXT_SYNC_EN),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR), .CAP_ADDR(CAP_ADDR)
  ) u_regs (
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .armed (sync_armed),
    .cmd   (cmd),
    .rdata (reg_rdata)
  );

  ext_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_sync_in),
    .rise     (ext_rise)
  );

  ext_sync_arm_fsm #(.NUM_CH(NUM_CH), .EXT_SYNC_EN(EXT_SYNC_EN)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .ext_rise (ext_rise),
    .armed    (sync_armed),
    .start    (ch_start)
  );

endmodule

// File: rtl/ext_sync_start_chk.sv
module ext_sync_start_chk
  import ext_sync_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          NUM_CH      = 4,
  parameter bit          EXT_SYNC_EN = 1'b1,
  parameter logic [15:0] CTRL_ADDR   = 16'h0044
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              sync_armed,
  input logic [NUM_CH-1:0] ch_start
);

  logic ctrl_wr, imm_wr, arm_only_wr, disarm_wr;
  assign ctrl_wr     = reg_wr_en && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign imm_wr      = ctrl_wr && reg_wdata[CTRL_IMMEDIATE_BIT];
  assign disarm_wr   = ctrl_wr && reg_wdata[CTRL_DISARM_BIT];
  assign arm_only_wr = ctrl_wr && reg_wdata[CTRL_ARM_BIT] && !reg_wdata[CTRL_DISARM_BIT];

  AST_START_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start[0] |-> ($past(sync_armed) || $past(imm_wr))); // R7

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start[0] && !$past(imm_wr)) |-> !sync_armed); // R4

  AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ch_start) == 0) || (ch_start == {NUM_CH{1'b1}})); // R12

  AST_DISARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_wr |=> !sync_armed); // R3

  AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_SYNC_EN && arm_only_wr && !sync_armed) |=> sync_armed); // R2

  AST_OFF_NEVER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !EXT_SYNC_EN |-> !sync_armed); // R10

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTRL_ADDR)) |-> (reg_rdata == '0)); // R8

endmodule

bind ext_sync_start_ctrl ext_sync_start_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH),
  .EXT_SYNC_EN(EXT_SYNC_EN), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .sync_armed (sync_armed),
  .ch_start   (ch_start)
);

// File: tb/tb_ext_sync_start_ctrl.sv
`timescale 1ns/1ps
module tb_ext_sync_start_ctrl;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int NUM_CH = 4;
  localparam logic [ADDR_W-1:0] CTRL = 16'h0044;
  localparam logic [ADDR_W-1:0] STAT = 16'h0068;
  localparam logic [ADDR_W-1:0] CAP  = 16'h000C;
  localparam logic [NUM_CH-1:0] ALL  = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ext_sync_in = 1'b0;
  logic              reg_wr_en = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] rdata_on, rdata_off;
  logic              armed_on, armed_off;
  logic [NUM_CH-1:0] start_on, start_off;

  int n_checks = 0;
  int n_fail   = 0;
  int cnt_on   = 0;
  int cnt_off  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ext_sync_start_ctrl #(.EXT_SYNC_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ext_sync_in(ext_sync_in),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_on), .sync_armed(armed_on), .ch_start(start_on)
  );

  ext_sync_start_ctrl #(.EXT_SYNC_EN(1'b0)) dut_noext (
    .clk(clk), .rst_n(rst_n), .ext_sync_in(ext_sync_in),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_off), .sync_armed(armed_off), .ch_start(start_off)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_on  != '0) cnt_on++;
      if (start_off != '0) cnt_off++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, return on the falling edge after the write edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = STAT; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    reg_addr = STAT; #1;
    check("R1 armed", armed_on, 0);
    check("R1 start", start_on, 0);
    check("R1 status", rdata_on, 0);
  endtask

  task automatic t_cap;
    reg_addr = CAP; #1;
    check("R9 cap on", rdata_on, 32'h0000_1000);
    check("R9 cap off", rdata_off, 32'h0);
    reg_addr = STAT;
  endtask

  task automatic t_arm_disarm;
    wr(CTRL, 32'h2);
    check("R2 armed pin", armed_on, 1);
    #1 check("R2 status", rdata_on, 1);
    reg_addr = CTRL; #1;
    check("R8 ctrl reads 0", rdata_on, 0);
    reg_addr = STAT;
    wr(CTRL, 32'h4);
    check("R3 disarm", armed_on, 0);
    wr(CTRL, 32'h6);
    check("R3 arm+disarm", armed_on, 0);
  endtask

  task automatic t_ext_edge;
    int c0;
    wr(CTRL, 32'h2);
    c0 = cnt_on;
    ext_sync_in = 1'b1;
    idle(2);
    check("R4 no early start", start_on, 0);
    idle(1);
    check("R4 start all lanes", start_on, ALL);
    check("R4 disarmed", armed_on, 0);
    check("R10 noext no start", start_off, 0);
    idle(1);
    check("R4 one cycle", start_on, 0);
    check("R4 single pulse", cnt_on - c0, 1);
    ext_sync_in = 1'b0;
    idle(4);
  endtask

  task automatic t_level_high;
    int c0;
    ext_sync_in = 1'b1;
    idle(5);
    c0 = cnt_on;
    wr(CTRL, 32'h2);
    idle(6);
    check("R5 no start on level", cnt_on - c0, 0);
    check("R5 still armed", armed_on, 1);
    ext_sync_in = 1'b0;
    idle(4);
    ext_sync_in = 1'b1;
    idle(3);
    check("R5 fresh edge fires", start_on, ALL);
    ext_sync_in = 1'b0;
    idle(4);
  endtask

  task automatic t_manual;
    int c0;
    wr(CTRL, 32'h2);
    wr(CTRL, 32'h100);
    check("R6 manual start", start_on, ALL);
    check("R6 disarmed", armed_on, 0);
    idle(1);
    check("R6 one cycle", start_on, 0);
    c0 = cnt_on;
    wr(CTRL, 32'h100);
    ext_sync_in = 1'b1;
    idle(6);
    check("R7 idle events ignored", cnt_on - c0, 0);
    check("R7 stays idle", armed_on, 0);
    ext_sync_in = 1'b0;
    idle(4);
  endtask

  task automatic t_noext;
    int c0;
    c0 = cnt_off;
    wr(CTRL, 32'h2);
    check("R10 no arm", armed_off, 0);
    #1 check("R10 status 0", rdata_off, 0);
    wr(CTRL, 32'h100);
    ext_sync_in = 1'b1;
    idle(6);
    check("R10 no start", cnt_off - c0, 0);
    ext_sync_in = 1'b0;
    idle(4);
  endtask

  task automatic t_immediate;
    wr(CTRL, 32'h2);
    wr(CTRL, 32'h1);
    check("R11 start on", start_on, ALL);
    check("R11 start off build", start_off, ALL);
    check("R11 armed kept", armed_on, 1);
    check("R12 lanes equal", (start_on == '0) || (start_on == ALL), 1);
    idle(1);
    check("R11 one cycle", start_on, 0);
    wr(CTRL, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap();
    t_arm_disarm();
    t_ext_edge();
    t_level_high();
    t_manual();
    t_noext();
    t_immediate();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule